// File: doc/BRIEF.md
# Mailbox interrupt mask and request logic

This block turns per-mailbox completion events of a sixteen-mailbox CAN controller into one interrupt request line. Each mailbox is either a transmitter or a receiver, selected by a direction input. A transmitter raises an event when its transmit-pending flag drops, which covers both a finished and a cancelled transmission. A receiver raises an event when its receive-pending flag rises at the end of a reception. Each event sets a sticky status bit. Status bits are kept even while the mailbox is masked.

Software reaches two registers over a small register bus. The first holds the mask, with its two bytes swapped relative to mailbox numbering. The second holds the status, which is cleared by writing ones. The block drives a per-mailbox vector of unmasked requests and a registered interrupt line that is the OR of that vector.

The block has no multi-state control flow. Every stored element is a one-bit register with a single next-state equation, so there are no enumerated states or transitions to list.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: The mask register is 16 bits wide and sits at bus address 0. A write with `bus_wr` high stores `bus_wdata` at the next rising clock edge. `bus_rdata` with address 0 returns the stored value bit for bit, without reordering.
- R2: While `rst_n` is low, and after reset ends, every mask bit is 1. Status, `req_vec` and `irq` are all 0.
- R3: For each mailbox m, `req_vec[m]` is 1 exactly when its status bit is 1 and its mask bit is 0. A mask bit of 1 blocks the request.
- R4: Mask register bit k controls mailbox (k+8) mod 16. So register bits 15..8 control mailboxes 7..0, and register bits 7..0 control mailboxes 15..8.
- R5: A mailbox with `dir_tx[m]`=1 records an event when `tx_pend[m]` was 1 at one rising edge and is 0 at the next. Its status bit is set at that second edge.
- R6: A mailbox with `dir_tx[m]`=0 records an event when `rx_pend[m]` was 0 at one rising edge and is 1 at the next. Its status bit is set at that second edge. The flag history resets to 0.
- R7: Events are recorded in status even while the mailbox is masked.
- R8: The status register sits at bus address 1, and a read returns bit m for mailbox m. Writing 1 to a bit clears it at the next edge. Writing 0 leaves the bit unchanged.
- R9: If an event and a clear of the same status bit fall on the same edge, the bit stays 1.
- R10: `irq` is a register loaded at each edge with the OR of `req_vec`, so it follows `req_vec` one cycle later. Clearing the mask bit of a mailbox whose status is already 1 raises `req_vec` at the write edge and `irq` one edge after that.
- R11: A flag that does not belong to a mailbox's direction has no effect on its status. For a transmitter that is `rx_pend` and a rising `tx_pend`. For a receiver that is `tx_pend` and a falling `rx_pend`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_tx | input | 16 | Per mailbox: 1 = transmitter, 0 = receiver |
| tx_pend | input | 16 | Per-mailbox transmit-pending flags |
| rx_pend | input | 16 | Per-mailbox receive-pending flags |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 = mask, 1 = status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| req_vec | output | 16 | Per-mailbox unmasked requests |
| irq | output | 1 | Registered OR of `req_vec` |

## Verification
A flag change driven before edge k sets status at edge k. It is therefore visible in the status readback and in `req_vec` right after edge k, while `irq` is still 0 at that point and becomes 1 only after edge k+1. A mask or status write issued before edge k changes the readback and `req_vec` after edge k and `irq` after edge k+1. The bench drives on falling edges and samples on the following falling edge for the first result and one falling edge later for `irq`. It checks `irq` at both points, so a response that is one cycle early or one cycle late is reported.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

    // Register select on the one-bit bus address.
    typedef enum logic {
        REG_MASK = 1'b0,
        REG_STAT = 1'b1
    } mbx_reg_e;

    // Reset value of each mask bit: masked.
    localparam logic MASK_RESET_BIT = 1'b1;

endpackage

// File: rtl/mbx_event_det.sv
module mbx_event_det #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] dir_tx,
    input  logic [N-1:0] tx_pend,
    input  logic [N-1:0] rx_pend,
    output logic [N-1:0] evt
);

    logic [N-1:0] tx_hist_q;
    logic [N-1:0] rx_hist_q;

    // Flag history, one sample per edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_hist_q <= '0;
            rx_hist_q <= '0;
        end else begin
            tx_hist_q <= tx_pend;
            rx_hist_q <= rx_pend;
        end
    end

    // Each mailbox picks its edge polarity from its direction.
    for (genvar m = 0; m < N; m++) begin : g_mbx
        logic tx_done;
        logic rx_done;
        always_comb begin
            tx_done = tx_hist_q[m] & ~tx_pend[m];
            rx_done = ~rx_hist_q[m] & rx_pend[m];
            evt[m]  = dir_tx[m] ? tx_done : rx_done;
        end
    end

endmodule

// File: rtl/mbx_mask_reg.sv
module mbx_mask_reg
    import mbx_irq_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] mask_raw,
    output logic [N-1:0] mask_mbx
);

    localparam int HALF = N / 2;

    // Stored in the software layout.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_raw <= {N{MASK_RESET_BIT}};
        end else if (wr_en) begin
            mask_raw <= wdata;
        end
    end

    // The upper byte of the register serves the lower mailboxes and vice versa.
    for (genvar m = 0; m < N; m++) begin : g_map
        localparam int RB = (m + HALF) % N;
        assign mask_mbx[m] = mask_raw[RB];
    end

endmodule

// File: rtl/mbx_status_reg.sv
module mbx_status_reg #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr_en,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] status
);

    logic [N-1:0] clr_vec;
    logic [N-1:0] status_d;

    always_comb begin
        clr_vec  = clr_en ? clr_bits : '0;
        // A fresh event outranks a clear on the same edge.
        status_d = (status & ~clr_vec) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status <= status_d;
        end
    end

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
    import mbx_irq_pkg::*;
#(
    parameter int MBX_COUNT = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MBX_COUNT-1:0] dir_tx,
    input  logic [MBX_COUNT-1:0] tx_pend,
    input  logic [MBX_COUNT-1:0] rx_pend,
    input  logic                 bus_wr,
    input  logic                 bus_addr,
    input  logic [MBX_COUNT-1:0] bus_wdata,
    output logic [MBX_COUNT-1:0] bus_rdata,
    output logic [MBX_COUNT-1:0] req_vec,
    output logic                 irq
);

    logic [MBX_COUNT-1:0] evt_w;
    logic [MBX_COUNT-1:0] mask_raw_w;
    logic [MBX_COUNT-1:0] mask_mbx_w;
    logic [MBX_COUNT-1:0] status_q;
    logic                 wr_mask;
    logic                 wr_stat;
    mbx_reg_e             sel;

    always_comb begin
        sel     = mbx_reg_e'(bus_addr);
        wr_mask = bus_wr && (sel == REG_MASK);
        wr_stat = bus_wr && (sel == REG_STAT);
    end

    mbx_event_det #(.N(MBX_COUNT)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir_tx  (dir_tx),
        .tx_pend (tx_pend),
        .rx_pend (rx_pend),
        .evt     (evt_w)
    );

    mbx_mask_reg #(.N(MBX_COUNT)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_mask),
        .wdata    (bus_wdata),
        .mask_raw (mask_raw_w),
        .mask_mbx (mask_mbx_w)
    );

    mbx_status_reg #(.N(MBX_COUNT)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_w),
        .clr_en   (wr_stat),
        .clr_bits (bus_wdata),
        .status   (status_q)
    );

    always_comb begin
        req_vec = status_q & ~mask_mbx_w;
        unique case (sel)
            REG_MASK: bus_rdata = mask_raw_w;
            REG_STAT: bus_rdata = status_q;
            default:  bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= |req_vec;
        end
    end

endmodule

// File: rtl/mbx_irq_ctrl_checker.sv
module mbx_irq_ctrl_checker
    import mbx_irq_pkg::*;
#(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] dir_tx,
    input logic [N-1:0] tx_pend,
    input logic [N-1:0] rx_pend,
    input logic         bus_wr,
    input logic         bus_addr,
    input logic [N-1:0] bus_wdata,
    input logic [N-1:0] req_vec,
    input logic         irq,
    input logic [N-1:0] evt,
    input logic [N-1:0] status,
    input logic [N-1:0] mask_mbx
);

    localparam int HALF = N / 2;

    logic         armed;
    logic [N-1:0] wdata_swapped;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assign wdata_swapped = {bus_wdata[HALF-1:0], bus_wdata[N-1:HALF]};

    // R10: the interrupt line is the previous cycle's combined request.
    assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|req_vec)));

    // R4: a mask write lands in mailbox order with the halves exchanged.
    assert_mask_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_MASK) |=> (mask_mbx == $past(wdata_swapped)));

    for (genvar m = 0; m < N; m++) begin : g_chk
        // R5: a falling transmit flag on a transmitter sets status.
        assert_tx_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && dir_tx[m] && $fell(tx_pend[m])) |-> (evt[m] ##1 status[m]));

        // R6: a rising receive flag on a receiver sets status.
        assert_rx_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && !dir_tx[m] && $rose(rx_pend[m])) |-> (evt[m] ##1 status[m]));

        // R9: an event always leaves status set, clear or not.
        assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            evt[m] |=> status[m]);

        // R8: a write-one clear without an event empties the bit.
        assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == REG_STAT && bus_wdata[m] && !evt[m]) |=> !status[m]);

        // R3: a request needs set status and a clear mask bit.
        assert_req_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
            req_vec[m] |-> (status[m] && !mask_mbx[m]));
    end

endmodule

bind mbx_irq_ctrl mbx_irq_ctrl_checker #(.N(MBX_COUNT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_tx    (dir_tx),
    .tx_pend   (tx_pend),
    .rx_pend   (rx_pend),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .req_vec   (req_vec),
    .irq       (irq),
    .evt       (evt_w),
    .status    (status_q),
    .mask_mbx  (mask_mbx_w)
);

// File: tb/mbx_irq_ctrl_test.sv
module mbx_irq_ctrl_test;

    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] dir_tx = '0;
    logic [N-1:0] tx_pend = '0;
    logic [N-1:0] rx_pend = '0;
    logic         bus_wr = 1'b0;
    logic         bus_addr = 1'b0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] req_vec;
    logic         irq;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    mbx_irq_ctrl #(.MBX_COUNT(N)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_tx    (dir_tx),
        .tx_pend   (tx_pend),
        .rx_pend   (rx_pend),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .req_vec   (req_vec),
        .irq       (irq)
    );

    function automatic int reg_bit(input int m);
        return (m + N / 2) % N;
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic rd(input logic a, output logic [N-1:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wr(input logic a, input logic [N-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    initial begin : watchdog
        #(4 * 200000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        logic [N-1:0] v;
        repeat (3) tick();
        // R2: reset values, sampled during reset and after release
        rd(1'b0, v); chk("R2 mask in reset", v, '1);
        rst_n = 1'b1;
        tick();
        rd(1'b0, v); chk("R2 mask", v, '1);
        rd(1'b1, v); chk("R2 status", v, '0);
        chk("R2 req_vec", req_vec, '0);
        chk("R2 irq", {15'd0, irq}, '0);

        // R1: readback of raw patterns
        for (int i = 0; i < N; i++) begin
            wr(1'b0, 16'h1 << i);
            rd(1'b0, v); chk("R1 walking one", v, 16'h1 << i);
        end
        wr(1'b0, 16'hA5C3); rd(1'b0, v); chk("R1 pattern", v, 16'hA5C3);
        wr(1'b0, '1);

        // R5 R6 R11 R3 R10 R8: per mailbox, per direction
        for (int d = 0; d < 2; d++) begin
            for (int m = 0; m < N; m++) begin
                dir_tx = (d == 1) ? '1 : '0;
                wr(1'b0, ~(16'h1 << reg_bit(m)));
                if (d == 1) begin
                    tx_pend[m] = 1'b1; rx_pend[m] = 1'b1;
                    tick();
                    rd(1'b1, v); chk("R11 tx rise / rx on transmitter", v, '0);
                    tx_pend[m] = 1'b0;
                    tick();
                    rd(1'b1, v); chk("R5 tx done status", v, 16'h1 << m);
                end else begin
                    tx_pend[m] = 1'b1;
                    tick();
                    tx_pend[m] = 1'b0;
                    tick();
                    rd(1'b1, v); chk("R11 tx on receiver", v, '0);
                    rx_pend[m] = 1'b1;
                    tick();
                    rd(1'b1, v); chk("R6 rx done status", v, 16'h1 << m);
                end
                chk("R3 req_vec unmasked", req_vec, 16'h1 << m);
                chk("R10 irq not yet", {15'd0, irq}, '0);
                rx_pend[m] = 1'b0;
                tick();
                chk("R10 irq raised", {15'd0, irq}, 16'h1);
                rd(1'b1, v); chk("R11 rx fall ignored", v, 16'h1 << m);
                wr(1'b1, '0);
                rd(1'b1, v); chk("R8 write zero keeps", v, 16'h1 << m);
                wr(1'b1, 16'h1 << m);
                rd(1'b1, v); chk("R8 write one clears", v, '0);
                chk("R3 req_vec after clear", req_vec, '0);
                tick();
                chk("R10 irq drops", {15'd0, irq}, '0);
            end
        end

        // R4: every register bit against every mailbox
        wr(1'b0, '1);
        dir_tx = '0;
        rx_pend = '1;
        tick();
        rd(1'b1, v); chk("R7 all recorded while masked", v, '1);
        chk("R3 all masked", req_vec, '0);
        rx_pend = '0;
        for (int k = 0; k < N; k++) begin
            wr(1'b0, ~(16'h1 << k));
            chk("R4 swap map", req_vec, 16'h1 << ((k + N / 2) % N));
        end
        wr(1'b0, '1);
        wr(1'b1, '1);
        tick();

        // R7 R10: masked event, then unmask
        for (int j = 0; j < 2; j++) begin
            int m;
            m = (j == 0) ? 2 : 13;
            rx_pend[m] = 1'b1;
            tick();
            rd(1'b1, v); chk("R7 masked event kept", v, 16'h1 << m);
            chk("R3 masked req", req_vec, '0);
            rx_pend[m] = 1'b0;
            tick();
            chk("R7 masked irq quiet", {15'd0, irq}, '0);
            wr(1'b0, ~(16'h1 << reg_bit(m)));
            chk("R10 unmask req", req_vec, 16'h1 << m);
            chk("R10 unmask irq lag", {15'd0, irq}, '0);
            tick();
            chk("R10 unmask irq", {15'd0, irq}, 16'h1);
            wr(1'b0, '1);
            wr(1'b1, '1);
        end

        // R9: event and clear on the same edge
        dir_tx = '1;
        tx_pend[5] = 1'b1;
        tick();
        tx_pend[5] = 1'b0;
        tick();
        tx_pend[5] = 1'b1;
        tick();
        tx_pend[5] = 1'b0;
        bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 16'h1 << 5;
        tick();
        bus_wr = 1'b0; bus_wdata = '0;
        rd(1'b1, v); chk("R9 event beats clear", v, 16'h1 << 5);
        wr(1'b1, '1);
        rd(1'b1, v); chk("R8 final clear", v, '0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule